// File: doc/BRIEF.md
# Dual-Channel Digipot Serial Controller

This block is the digital side of a two-channel digital potentiometer. A host sends 24-bit frames over a chip-select, serial clock and data-in port. Each frame carries a command, a channel address and a 10-bit wiper value. Every channel has a live wiper register, which drives the wiper code output, and a nonvolatile shadow register. The shadow register is modelled as flops, and its store and restore operations hold a ready flag low for a fixed number of system clocks.

The serial inputs are treated as synchronous to the system clock and are edge-detected there. A serial data output re-emits the previous frame so that several devices can be chained. After a readback command, the next frame's output carries register contents instead. A write-protect input freezes everything except the restore paths. A preset strobe reloads all wipers from their shadows.

Top module: `digipot_ser_ctrl`

## Requirements
- R1: After reset every wiper and every shadow register holds midscale (512), rdy_o is high and sdo_o is 0.
- R2: Data-in is taken MSB first on each rising edge of sclk_i while csn_i is low. The command is bits [23:20], the address is bits [19:16] and the value is bits [9:0]; bits [15:10] are ignored. Command 11 writes the value into the addressed wiper. Nothing takes effect until csn_i rises.
- R3: A frame with any bit count other than 24 when csn_i rises changes no wiper, no shadow and no serial output content.
- R4: While csn_i is low, sdo_o presents the 24 bits of the previous accepted frame, MSB first. The first bit appears after csn_i falls, and the output advances after each rising sclk_i edge.
- R5: Command 9 (shadow) and command 10 (wiper) make the next frame's sdo_o carry 14 zero bits followed by the 10-bit addressed value. An unused address reads as zero.
- R6: Command 3 writes the value into the addressed shadow, command 2 copies the addressed wiper into its shadow, command 1 reloads the addressed wiper from its shadow, and command 8 reloads all wipers. Address 0 selects channel 1 and address 1 selects channel 2; other addresses change nothing.
- R7: While wp_ni is low, commands 11, 3 and 2 change nothing, while commands 1 and 8 and the preset still take effect.
- R8: A rising edge on pr_i reloads every wiper from its shadow and starts a busy period.
- R9: rdy_o goes low for BUSY_CYC system clocks after commands 2, 3, 8, 9 or 10, whether or not write protect blocked them, and after a preset. Commands 1 and 11 leave rdy_o high.
- R10: A frame that completes while rdy_o is low is ignored, and the following frame still echoes the last accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (echo or readback) |
| wp_ni | input | 1 | Active-low write protect |
| pr_i | input | 1 | Preset strobe, acts on its rising edge |
| rdy_o | output | 1 | High when idle, low while busy |
| wiper_o | output | NUM_CH*VAL_W | Wiper codes, channel 1 in the low bits |

## Verification
The bench builds the block with NUM_CH=2, VAL_W=10 and BUSY_CYC=150. A busy period of 150 clocks is longer than one full frame at the bench's serial rate, so a frame can start and finish entirely inside a store or readback busy window. This is what lets the bench check that such frames are discarded. With the default channel count, address 5 stays unused, which exercises the no-effect and zero-readback paths for unused addresses.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam int FRAME_W = 24;
  localparam int CMD_LSB = 20;
  localparam int ADR_LSB = 16;
  localparam int FLD_W   = 4;

  localparam logic [FLD_W-1:0] CMD_NOP      = 4'd0;
  localparam logic [FLD_W-1:0] CMD_RESTORE  = 4'd1;
  localparam logic [FLD_W-1:0] CMD_STORE    = 4'd2;
  localparam logic [FLD_W-1:0] CMD_WR_NV    = 4'd3;
  localparam logic [FLD_W-1:0] CMD_REST_ALL = 4'd8;
  localparam logic [FLD_W-1:0] CMD_RD_NV    = 4'd9;
  localparam logic [FLD_W-1:0] CMD_RD_WIPER = 4'd10;
  localparam logic [FLD_W-1:0] CMD_WR_WIPER = 4'd11;
endpackage

// File: rtl/digipot_rx.sv
module digipot_rx import digipot_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               sdi_i,
  input  logic               hold_we_i,
  input  logic [FRAME_W-1:0] hold_d_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_done_o,
  output logic               sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclk_q, csn_q;
  logic sclk_rise, cs_fall, cs_rise, shift_en;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q, hold_q;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign cs_fall   = ~csn_i & csn_q;
  assign cs_rise   = csn_i & ~csn_q;
  assign shift_en  = sclk_rise & ~csn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      hold_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
      if (cs_fall) begin
        cnt_q <= '0;
        tx_q  <= hold_q;
      end else if (shift_en) begin
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (hold_we_i) hold_q <= hold_d_i;
    end
  end

  assign frame_o      = rx_q;
  assign frame_done_o = cs_rise & (cnt_q == CNT_FULL);
  assign sdo_o        = tx_q[FRAME_W-1];

  // bad-length frames never reach the echo buffer
  p_short_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && cnt_q != CNT_FULL) |=> $stable(hold_q));
  p_tx_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (tx_q == $past(hold_q)));
endmodule

// File: rtl/digipot_busy.sv
module digipot_busy #(
  parameter int BUSY_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rdy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign rdy_o = (cnt_q == '0);

  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rdy_o);
  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !start_i) |=> rdy_o);
endmodule

// File: rtl/digipot_chan.sv
module digipot_chan #(
  parameter int VAL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_wiper_i,
  input  logic [VAL_W-1:0] wiper_d_i,
  input  logic             wr_shadow_i,
  input  logic [VAL_W-1:0] shadow_d_i,
  output logic [VAL_W-1:0] wiper_o,
  output logic [VAL_W-1:0] shadow_o
);
  localparam logic [VAL_W-1:0] MID = VAL_W'(1) << (VAL_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o  <= MID;
      shadow_o <= MID;
    end else begin
      if (wr_wiper_i)  wiper_o  <= wiper_d_i;
      if (wr_shadow_i) shadow_o <= shadow_d_i;
    end
  end
endmodule

// File: rtl/digipot_ser_ctrl.sv
module digipot_ser_ctrl import digipot_pkg::*; #(
  parameter int NUM_CH   = 2,
  parameter int VAL_W    = 10,
  parameter int BUSY_CYC = 4000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sclk_i,
  input  logic                    csn_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  input  logic                    wp_ni,
  input  logic                    pr_i,
  output logic                    rdy_o,
  output logic [NUM_CH*VAL_W-1:0] wiper_o
);
  localparam int PAD_W = FRAME_W - VAL_W;

  logic [FRAME_W-1:0] frame, hold_d;
  logic               frame_done, exec, pr_q, pr_rise, busy_start, is_rb;
  logic [FLD_W-1:0]   cmd, addr;
  logic [VAL_W-1:0]   val, rb_val;
  logic [VAL_W-1:0]   wiper_q  [NUM_CH];
  logic [VAL_W-1:0]   shadow_q [NUM_CH];
  logic [NUM_CH*VAL_W-1:0] shadow_flat;

  digipot_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .csn_i        (csn_i),
    .sdi_i        (sdi_i),
    .hold_we_i    (exec),
    .hold_d_i     (hold_d),
    .frame_o      (frame),
    .frame_done_o (frame_done),
    .sdo_o        (sdo_o)
  );

  assign cmd   = frame[CMD_LSB +: FLD_W];
  assign addr  = frame[ADR_LSB +: FLD_W];
  assign val   = frame[VAL_W-1:0];
  assign exec  = frame_done & rdy_o;
  assign is_rb = (cmd == CMD_RD_NV) || (cmd == CMD_RD_WIPER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pr_q <= 1'b1;
    else         pr_q <= pr_i;
  end
  assign pr_rise = pr_i & ~pr_q;

  always_comb begin
    rb_val = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr == FLD_W'(c))
        rb_val = (cmd == CMD_RD_NV) ? shadow_q[c] : wiper_q[c];
  end
  assign hold_d = is_rb ? {{PAD_W{1'b0}}, rb_val} : frame;

  assign busy_start = pr_rise | (exec & (cmd == CMD_STORE || cmd == CMD_WR_NV ||
                      cmd == CMD_REST_ALL || is_rb));

  digipot_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (busy_start),
    .rdy_o   (rdy_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, wr_w, wr_s;
    logic [VAL_W-1:0] w_d, s_d;
    assign hit  = exec & (addr == FLD_W'(c));
    // restore paths bypass write protect
    assign wr_w = pr_rise | (exec & cmd == CMD_REST_ALL) | (hit & cmd == CMD_RESTORE) |
                  (hit & wp_ni & cmd == CMD_WR_WIPER);
    assign w_d  = (!pr_rise && cmd == CMD_WR_WIPER) ? val : shadow_q[c];
    assign wr_s = hit & wp_ni & (cmd == CMD_STORE || cmd == CMD_WR_NV);
    assign s_d  = (cmd == CMD_STORE) ? wiper_q[c] : val;

    digipot_chan #(.VAL_W(VAL_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_wiper_i  (wr_w),
      .wiper_d_i   (w_d),
      .wr_shadow_i (wr_s),
      .shadow_d_i  (s_d),
      .wiper_o     (wiper_q[c]),
      .shadow_o    (shadow_q[c])
    );
    assign wiper_o[c*VAL_W +: VAL_W]     = wiper_q[c];
    assign shadow_flat[c*VAL_W +: VAL_W] = shadow_q[c];
  end

  p_wp_shadow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> $stable(shadow_flat));
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |=> $stable(shadow_flat));
  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_rise |=> (wiper_o == $past(shadow_flat)));
  p_idle_wiper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done && !pr_rise) |=> $stable(wiper_o));
endmodule

// File: tb/digipot_ser_ctrl_bench.sv
`timescale 1ns/1ps
module digipot_ser_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, wp_n = 1'b1, pr = 1'b0;
  logic sdo, rdy;
  logic [19:0] wiper;

  always #2.5 clk = ~clk;

  digipot_ser_ctrl #(.NUM_CH(2), .VAL_W(10), .BUSY_CYC(150)) u_digipot_ser_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .wp_ni(wp_n), .pr_i(pr), .rdy_o(rdy), .wiper_o(wiper));

  typedef struct { string req; logic [23:0] exp; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  logic [9:0]  m_w [2];
  logic [9:0]  m_s [2];
  logic [23:0] m_prev = '0;
  bit          m_prev_rb = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [9:0] v);
    return {c, a, 6'b0, v};
  endfunction

  task automatic check_wipers(input string req);
    check(req, {22'b0, wiper[9:0]},  {22'b0, m_w[0]});
    check(req, {22'b0, wiper[19:10]}, {22'b0, m_w[1]});
  endtask

  task automatic apply_model(input logic [23:0] w);
    logic [3:0] c, a;
    logic [9:0] v, rb;
    c = w[23:20]; a = w[19:16]; v = w[9:0];
    rb = (a < 2) ? ((c == 4'd9) ? m_s[a[0]] : m_w[a[0]]) : 10'd0;
    if (c == 4'd9 || c == 4'd10) begin m_prev = {14'b0, rb}; m_prev_rb = 1'b1; end
    else begin m_prev = w; m_prev_rb = 1'b0; end
    if (a < 2) begin
      case (c)
        4'd11: if (wp_n) m_w[a[0]] = v;
        4'd3:  if (wp_n) m_s[a[0]] = v;
        4'd2:  if (wp_n) m_s[a[0]] = m_w[a[0]];
        4'd1:  m_w[a[0]] = m_s[a[0]];
        default: ;
      endcase
    end
    if (c == 4'd8) begin m_w[0] = m_s[0]; m_w[1] = m_s[1]; end
  endtask

  // driver: push the expected echo, clock bits out, update the model if accepted
  task automatic send(input logic [23:0] w, input int nbits, input bit accept);
    item_t it;
    if (nbits == 24) begin
      it.req = m_prev_rb ? "R5" : "R4";
      it.exp = m_prev;
      exp_q.push_back(it);
    end
    csn = 1'b0;
    tick(2);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      sclk = 1'b0; tick(2);
      sclk = 1'b1; tick(2);
    end
    sclk = 1'b0; tick(2);
    check_wipers("R2 no effect before csn rises");
    csn = 1'b1;
    tick(3);
    if (accept && nbits == 24) apply_model(w);
  endtask

  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
    tick(2);
  endtask

  // monitor: collect sdo bits per frame and compare with the scoreboard
  initial begin
    logic [23:0] word;
    int n;
    forever begin
      @(negedge csn);
      n = 0; word = '0;
      while (csn === 1'b0) begin
        @(posedge sclk or posedge csn);
        if (csn === 1'b0) begin word = {word[22:0], sdo}; n++; end
      end
      if (n == 24) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R4: actual 0x%0h expected none queued", word);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({it.req, " sdo stream"}, {8'b0, word}, {8'b0, it.exp});
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_w[0] = 10'd512; m_w[1] = 10'd512; m_s[0] = 10'd512; m_s[1] = 10'd512;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check_wipers("R1 reset wipers");
    check("R1 reset rdy", {31'b0, rdy}, 32'd1);
    check("R1 reset sdo", {31'b0, sdo}, 32'd0);

    // R2 wiper writes, R9 command 11 leaves ready high
    send(mk(4'd11, 4'd0, 10'h123), 24, 1'b1);
    check_wipers("R2 write wiper ch1");
    check("R9 cmd11 rdy", {31'b0, rdy}, 32'd1);
    send(mk(4'd11, 4'd1, 10'h3FF), 24, 1'b1);
    check_wipers("R2 write wiper ch2");

    // R6 store, R9 busy, R5 readback shadow
    send(mk(4'd2, 4'd0, 10'h000), 24, 1'b1);
    check("R9 store busy", {31'b0, rdy}, 32'd0);
    wait_rdy();
    send(mk(4'd9, 4'd0, 10'h000), 24, 1'b1);
    check("R9 readback busy", {31'b0, rdy}, 32'd0);
    wait_rdy();
    send(mk(4'd10, 4'd1, 10'h000), 24, 1'b1);
    wait_rdy();
    send(24'h0AB3C5, 24, 1'b1);
    send(24'h054C3A, 24, 1'b1);

    // R6 shadow write then single-channel restore
    send(mk(4'd3, 4'd1, 10'h055), 24, 1'b1);
    wait_rdy();
    check_wipers("R6 shadow write leaves wiper");
    send(mk(4'd1, 4'd1, 10'h000), 24, 1'b1);
    check_wipers("R6 restore ch2");
    check("R9 cmd1 rdy", {31'b0, rdy}, 32'd1);

    // R3 bad-length frames
    send(mk(4'd11, 4'd0, 10'h000), 20, 1'b0);
    check_wipers("R3 short frame");
    send(mk(4'd11, 4'd0, 10'h000), 25, 1'b0);
    check_wipers("R3 long frame");
    send(24'h0F00FF, 24, 1'b1);

    // R7 write protect
    send(mk(4'd11, 4'd0, 10'h2AA), 24, 1'b1);
    check_wipers("R2 wiper ch1 before protect");
    wp_n = 1'b0;
    tick(2);
    send(mk(4'd11, 4'd1, 10'h200), 24, 1'b1);
    check_wipers("R7 protected wiper write");
    send(mk(4'd3, 4'd0, 10'h111), 24, 1'b1);
    check("R9 protected store still busy", {31'b0, rdy}, 32'd0);
    wait_rdy();
    send(mk(4'd8, 4'd0, 10'h000), 24, 1'b1);
    wait_rdy();
    check_wipers("R7 restore-all under protect");
    send(mk(4'd9, 4'd0, 10'h000), 24, 1'b1);
    wait_rdy();
    wp_n = 1'b1;
    send(24'h000000, 24, 1'b1);

    // R8 preset
    send(mk(4'd11, 4'd0, 10'h001), 24, 1'b1);
    send(mk(4'd11, 4'd1, 10'h002), 24, 1'b1);
    check_wipers("R2 wipers before preset");
    pr = 1'b1;
    tick(3);
    pr = 1'b0;
    m_w[0] = m_s[0]; m_w[1] = m_s[1];
    check_wipers("R8 preset reload");
    check("R8 preset busy", {31'b0, rdy}, 32'd0);
    wait_rdy();

    // R10 frame during busy is ignored
    send(mk(4'd11, 4'd1, 10'h0F0), 24, 1'b1);
    send(mk(4'd2, 4'd1, 10'h000), 24, 1'b1);
    send(mk(4'd11, 4'd0, 10'h3C3), 24, 1'b0);
    check_wipers("R10 frame ignored while busy");
    wait_rdy();
    send(mk(4'd9, 4'd1, 10'h000), 24, 1'b1);
    wait_rdy();

    // R6 / R5 unused address
    send(mk(4'd11, 4'd5, 10'h155), 24, 1'b1);
    check_wipers("R6 unused address");
    send(mk(4'd10, 4'd5, 10'h000), 24, 1'b1);
    wait_rdy();
    send(24'h0C3A5A, 24, 1'b1);

    check("R4 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule